// File: doc/BRIEF.md
# External Request Conditioner

This block turns an asynchronous service request from an off-chip device into a clean, single-clock-domain request for a transfer engine. The raw request first crosses a chain of flip-flops on the system clock. After that it is read in one of two ways. In level mode the synchronized level itself is the request. In edge mode a chosen transition, either rising or falling, records a pending request. That pending request is visible as a status output.

Once the engine reports with a one-cycle handshake that it has taken the request, the block drives an acknowledge to the device. The acknowledge lasts the programmed number of wait states. At its end the pending record is cleared. An edge that arrives while acknowledge is high is kept as a new request. After every acknowledge the block waits one idle cycle before it looks at the request again. This lets a device that dropped its level during acknowledge be seen as idle, so a stale level does not start a second transfer.

Top module: `ext_req_cond`

## Requirements
- R1: While `rst_n` is low, `svc_req_o`, `ack_o` and `pending_o` are all low, and reset takes effect without a clock edge.
- R2: In level mode (`edge_mode_i` = 0), `svc_req_o` goes high on the third rising clock edge after `req_raw_i` goes high: two synchronizer stages plus one state register.
- R3: In edge mode (`edge_mode_i` = 1) with `fall_sel_i` = 0, a rising edge on `req_raw_i` sets `pending_o` on the third clock edge and raises `svc_req_o` on the fourth.
- R4: In edge mode, only the selected transition makes a request: rising when `fall_sel_i` = 0, falling when `fall_sel_i` = 1. The other transition leaves `svc_req_o` and `pending_o` low.
- R5: `svc_req_o` stays high until `xfer_done_i` is sampled high. On that edge `svc_req_o` drops and `ack_o` rises.
- R6: `ack_o` stays high for exactly `wait_states_i` cycles. A value of 0 gives one cycle.
- R7: `pending_o` clears on the edge where `ack_o` falls. In level mode `pending_o` is always low.
- R8: In edge mode, a selected edge that reaches the edge detector while `ack_o` is high leaves `pending_o` high after `ack_o` falls, and a new request follows.
- R9: After `ack_o` falls, the request is not sampled again for one cycle. A level dropped during acknowledge therefore makes no further request. A level still held high requests again on the second edge after `ack_o` falls.
- R10: `svc_req_o` and `ack_o` are never high together, and `svc_req_o` is low in the cycle right after `ack_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_raw_i | input | 1 | Raw request from the external device, asynchronous |
| edge_mode_i | input | 1 | 1 = edge-sensitive, 0 = level-sensitive |
| fall_sel_i | input | 1 | Edge mode only: 1 = falling edge, 0 = rising edge |
| wait_states_i | input | WS_W | Acknowledge length in cycles (0 treated as 1) |
| xfer_done_i | input | 1 | One-cycle handshake from the engine: request taken |
| svc_req_o | output | 1 | Conditioned service request to the engine |
| ack_o | output | 1 | Acknowledge to the external device |
| pending_o | output | 1 | Edge mode: a request is recorded |

## Verification
A wrong synchronizer depth or a missing edge-detector register shows up as a shift in request latency of one or more cycles. The bench counts that latency exactly. A stuck or badly reloaded acknowledge counter makes `ack_o` one or more cycles too long or too short, and this is visible during the very first transfer. A pending record that is lost or never cleared appears at the ports within two cycles of acknowledge ending: a missing re-request, or a spurious one. A missing idle hold shows up as a second `svc_req_o` two edges after acknowledge, even when the device dropped its level in time.

// File: rtl/xreq_pkg.sv
package xreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_HOLD = 2'd3
  } xreq_state_e;

  // Acknowledge length: a zero count still gives one cycle.
  function automatic logic [15:0] ack_cycles(input logic [15:0] ws);
    return (ws == 16'd0) ? 16'd1 : ws;
  endfunction

endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xreq_edge.sv
module xreq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  logic rise_w, fall_w;
  assign rise_w = lvl_i & ~prev_q;
  assign fall_w = ~lvl_i & prev_q;
  assign evt_o  = fall_sel_i ? fall_w : rise_w;
endmodule

// File: rtl/xreq_seq.sv
module xreq_seq
  import xreq_pkg::*;
#(
  parameter int WS_W     = 4,
  parameter int HOLD_CYC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_mode_i,
  input  logic            lvl_i,
  input  logic            evt_i,
  input  logic [WS_W-1:0] wait_states_i,
  input  logic            xfer_done_i,
  output logic            svc_req_o,
  output logic            ack_o,
  output logic            pending_o,
  output logic            ack_end_o
);
  localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC + 1);

  xreq_state_e     state_q, state_d;
  logic [WS_W-1:0] cnt_q;
  logic [HW-1:0]   hold_q;
  logic            pend_q, again_q;
  logic            want_w;

  assign ack_end_o = (state_q == ST_ACK) && (cnt_q == '0);
  assign want_w    = edge_mode_i ? pend_q : lvl_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (want_w)            state_d = ST_REQ;
      ST_REQ:  if (xfer_done_i)       state_d = ST_ACK;
      ST_ACK:  if (cnt_q == '0)       state_d = ST_HOLD;
      ST_HOLD: if (hold_q == '0)      state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REQ && xfer_done_i)
        cnt_q <= WS_W'(ack_cycles(16'(wait_states_i)) - 16'd1);
      else if (state_q == ST_ACK && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
      if (ack_end_o)
        hold_q <= HW'(HOLD_CYC - 1);
      else if (state_q == ST_HOLD && hold_q != '0)
        hold_q <= hold_q - 1'b1;
    end
  end

  // Pending record plus a second record for edges seen during acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      again_q <= 1'b0;
    end else if (!edge_mode_i) begin
      pend_q  <= 1'b0;
      again_q <= 1'b0;
    end else begin
      pend_q  <= evt_i | (ack_end_o ? again_q : pend_q);
      if (ack_end_o)                        again_q <= 1'b0;
      else if (evt_i && state_q == ST_ACK)  again_q <= 1'b1;
    end
  end

  assign svc_req_o = (state_q == ST_REQ);
  assign ack_o     = (state_q == ST_ACK);
  assign pending_o = pend_q;
endmodule

// File: rtl/ext_req_cond.sv
module ext_req_cond #(
  parameter int WS_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_raw_i,
  input  logic            edge_mode_i,
  input  logic            fall_sel_i,
  input  logic [WS_W-1:0] wait_states_i,
  input  logic            xfer_done_i,
  output logic            svc_req_o,
  output logic            ack_o,
  output logic            pending_o
);
  localparam int HOLD_CYC = SYNC_STAGES - 1;

  logic sync_lvl;
  logic edge_evt;
  logic ack_end;

  xreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_raw_i), .q_o(sync_lvl)
  );

  xreq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_lvl),
    .fall_sel_i(fall_sel_i), .evt_o(edge_evt)
  );

  xreq_seq #(.WS_W(WS_W), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .edge_mode_i(edge_mode_i),
    .lvl_i(sync_lvl), .evt_i(edge_evt), .wait_states_i(wait_states_i),
    .xfer_done_i(xfer_done_i), .svc_req_o(svc_req_o), .ack_o(ack_o),
    .pending_o(pending_o), .ack_end_o(ack_end)
  );
endmodule

// File: rtl/xreq_checker.sv
module xreq_checker
  import xreq_pkg::*;
#(
  parameter int WS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            edge_mode_i,
  input logic [WS_W-1:0] wait_states_i,
  input logic            xfer_done_i,
  input logic            svc_req_o,
  input logic            ack_o,
  input logic            pending_o,
  input logic            sync_lvl,
  input logic            edge_evt
);
  logic [WS_W-1:0] len_q, run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      run_q <= '0;
    end else begin
      if (svc_req_o && xfer_done_i)
        len_q <= WS_W'(ack_cycles(16'(wait_states_i)));
      run_q <= ack_o ? run_q + 1'b1 : '0;
    end
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_req_o && ack_o));
  assert_post_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !svc_req_o);
  assert_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req_o && xfer_done_i |=> ack_o && !svc_req_o);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req_o && !xfer_done_i |=> svc_req_o);
  assert_ack_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> run_q < len_q);
  assert_ack_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o && ({1'b0, run_q} + 1'b1 < {1'b0, len_q}) |=> ack_o);
  assert_level_nopend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode_i |=> !pending_o);
  assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i && edge_evt |=> pending_o);
  assert_level_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_req_o) && !edge_mode_i |-> $past(sync_lvl));
endmodule

bind ext_req_cond xreq_checker #(.WS_W(WS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_mode_i(edge_mode_i),
  .wait_states_i(wait_states_i), .xfer_done_i(xfer_done_i),
  .svc_req_o(svc_req_o), .ack_o(ack_o), .pending_o(pending_o),
  .sync_lvl(sync_lvl), .edge_evt(edge_evt)
);

// File: tb/ext_req_cond_test.sv
module ext_req_cond_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0, edge_m = 1'b0, fall = 1'b0, done = 1'b0;
  logic [3:0] ws = 4'd1;
  logic       svc, ack, pend;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  ext_req_cond uut (
    .clk(clk), .rst_n(rst_n), .req_raw_i(raw), .edge_mode_i(edge_m),
    .fall_sel_i(fall), .wait_states_i(ws), .xfer_done_i(done),
    .svc_req_o(svc), .ack_o(ack), .pending_o(pend)
  );

  // {edge, fall, ws[3:0], request latency[3:0], ack length[3:0]}
  localparam logic [13:0] VEC [6] = '{
    {1'b0, 1'b0, 4'd2,  4'd3, 4'd2},
    {1'b0, 1'b0, 4'd0,  4'd3, 4'd1},
    {1'b1, 1'b0, 4'd3,  4'd4, 4'd3},
    {1'b1, 1'b1, 4'd1,  4'd4, 4'd1},
    {1'b1, 1'b0, 4'd15, 4'd4, 4'd15},
    {1'b1, 1'b1, 4'd0,  4'd4, 4'd1}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_svc(output int lat);
    lat = 0;
    do begin step(); lat++; end while (!svc && lat < 20);
  endtask

  task automatic drain_ack(input bit drop_lvl, output int n);
    n = 0;
    while (ack && n < 40) begin
      n++;
      if (drop_lvl) raw = 1'b0;
      step();
    end
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, n;
    bit idle;
    repeat (3) step();
    check(!svc && !ack && !pend, "R1", {svc, ack, pend}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) begin
      edge_m = VEC[i][13]; fall = VEC[i][12]; ws = VEC[i][11:8];
      idle = VEC[i][13] & VEC[i][12];
      raw = idle;
      repeat (6) begin
        step();
        check(!svc && !pend, "R4", {svc, pend}, 0);
      end
      raw = ~idle;
      wait_svc(lat);
      check(lat == int'(VEC[i][7:4]), edge_m ? "R3" : "R2", lat, VEC[i][7:4]);
      check(pend == edge_m, edge_m ? "R3" : "R7", pend, edge_m);
      repeat (3) step();
      check(svc, "R5", svc, 1);
      done = 1'b1; step(); done = 1'b0;
      check(ack && !svc, "R5", {ack, svc}, 2);
      drain_ack(!edge_m, n);
      check(n == int'(VEC[i][3:0]), "R6", n, VEC[i][3:0]);
      check(!pend, "R7", pend, 0);
      if (edge_m) raw = idle;
      repeat (5) begin
        step();
        check(!svc, edge_m ? "R4" : "R9", svc, 0);
      end
    end

    // R8: a new rising edge during a long acknowledge
    edge_m = 1'b1; fall = 1'b0; ws = 4'd6; raw = 1'b0;
    repeat (4) step();
    raw = 1'b1;
    wait_svc(lat);
    done = 1'b1; step(); done = 1'b0;
    raw = 1'b0; step(); raw = 1'b1;
    drain_ack(1'b0, n);
    check(pend, "R8", pend, 1);
    wait_svc(lat);
    check(svc, "R8", svc, 1);
    done = 1'b1; step(); done = 1'b0;
    drain_ack(1'b0, n);
    raw = 1'b0;
    repeat (4) step();
    check(!svc && !pend, "R8", {svc, pend}, 0);

    // R9/R10: a level still high after acknowledge requests again after one idle cycle
    edge_m = 1'b0; ws = 4'd2; raw = 1'b1;
    wait_svc(lat);
    done = 1'b1; step(); done = 1'b0;
    drain_ack(1'b0, n);
    check(!svc, "R10", svc, 0);
    step();
    check(!svc, "R9", svc, 0);
    step();
    check(svc, "R9", svc, 1);
    done = 1'b1; step(); done = 1'b0;
    drain_ack(1'b1, n);
    repeat (4) step();
    check(!svc, "R9", svc, 0);

    // R1: reset in the middle of an acknowledge
    raw = 1'b1;
    wait_svc(lat);
    done = 1'b1; step(); done = 1'b0;
    rst_n = 1'b0; #1;
    check(!svc && !ack && !pend, "R1", {svc, ack, pend}, 0);
    raw = 1'b0;
    step(); rst_n = 1'b1;
    repeat (4) step();
    check(!svc && !ack, "R1", {svc, ack}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule